// File: doc/BRIEF.md
# Selectable-Waveform Numerically Controlled Oscillator

This block is the signal engine of a programmable waveform source. A 28-bit phase accumulator, clocked by the master clock, advances by a chosen frequency word every cycle, so the output frequency equals the clock rate times the word divided by 2^28. A chosen 12-bit phase offset is added to the top twelve accumulator bits to shift the waveform by offset/4096 of a turn.

The shaped result is a 10-bit unsigned sample: a sine from a quarter-wave table that is computed at elaboration, or a triangle. In square mode a one-bit output shows either the accumulator MSB or a divide-by-two of it. Two register banks of frequency and phase values are held by a separate interface block and presented on ports, together with the decoded control fields. Select bits pick which bank drives the oscillator. Further control inputs hold the accumulator at zero, freeze it, or mute the sample path.

Top module: `wavegen_core`

## Requirements
- R1: After reset the accumulator is zero. On every clock edge with `acc_clear` and `acc_freeze` low it grows by the selected frequency word, modulo 2^28.
- R2: `freq_pick`=1 selects `freq_b` (0 selects `freq_a`). `phase_pick`=1 selects `phase_b` (0 selects `phase_a`).
- R3: The waveform phase is accumulator bits [27:16] plus the selected offset, modulo 4096.
- R4: While `acc_clear` is high, the accumulator and the half-rate divider are cleared on each edge. Advancing resumes on the first edge after it falls. It takes priority over `acc_freeze`.
- R5: While `acc_freeze` is high (and `acc_clear` low), the accumulator and the divider keep their values.
- R6: Sine (`sq_mode`=0, `tri_mode`=0): with P = phase[11:2], `sample` is within 2 LSB of 511.5 + 511.5·sin(2π(P+0.5)/1024).
- R7: Triangle (`sq_mode`=0, `tri_mode`=1): with Q = phase[11:1], `sample` = Q[9:0] when Q[10]=0 and 1023 − Q[9:0] when Q[10]=1.
- R8: Square (`sq_mode`=1): `sq_out` equals accumulator bit 27 when `sq_full`=1 and the divider when `sq_full`=0. `sample` is 1023 when `sq_out` is 1 and 0 otherwise, and `tri_mode` is ignored. With `sq_mode`=0, `sq_out` is 0.
- R9: The half-rate divider flips on each edge where accumulator bit 27 goes from 0 to 1.
- R10: `dac_mute`=1 forces `sample` to 0 in every mode and leaves `sq_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_a | input | 28 | Frequency word, bank A |
| freq_b | input | 28 | Frequency word, bank B |
| phase_a | input | 12 | Phase offset, bank A |
| phase_b | input | 12 | Phase offset, bank B |
| freq_pick | input | 1 | Frequency bank select |
| phase_pick | input | 1 | Phase bank select |
| acc_clear | input | 1 | Hold accumulator and divider at zero |
| acc_freeze | input | 1 | Stop accumulator advance |
| dac_mute | input | 1 | Force sample output to zero |
| sq_mode | input | 1 | Square-wave mode |
| sq_full | input | 1 | Square at MSB rate (1) or half rate (0) |
| tri_mode | input | 1 | Triangle (1) or sine (0) when not square |
| sample | output | 10 | Unsigned waveform sample |
| sq_out | output | 1 | One-bit square output |

## Verification
On every cycle the assertions check the accumulator step against the selected frequency word, clearing and freezing, the divider flip on each MSB rise, the mute forcing, and the idle square output. The exact shape values cannot be checked by a property: sine accuracy against the ideal curve, the triangle fold, and the phase-offset addition. The bench shows these by sweeping every phase code with a one-code step per cycle. Its scenarios also cover the interaction of bank selection, the square rates, and recovery after clear or freeze.

// File: rtl/dds_pkg.sv
// Package: shared control bundle and the elaboration-time sine magnitude
// function for the waveform oscillator. Assumes integer-only math.
package dds_pkg;

    typedef struct packed {
        logic clear;
        logic freeze;
        logic mute;
        logic sq_mode;
        logic sq_full;
        logic tri_mode;
    } wave_ctl_t;

    // Rounded amp*sin((2i+1)*90/(2n) degrees) via a rational sine approximation.
    function automatic int sine_mag(input int idx, input int aw, input int amp);
        longint n, a, q, num, den;
        n   = longint'(1) << aw;
        a   = (2 * longint'(idx) + 1) * 45;
        q   = a * (180 * n - a);
        num = 4 * q;
        den = 40500 * n * n - q;
        return int'((2 * longint'(amp) * num + den) / (2 * den));
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator with a divide-by-two of its MSB.
// Assumes: step is stable around the edge; clear outranks freeze.
module dds_phase_acc #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             freeze,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc,
    output logic             half_sq
);
    localparam int MSB = ACC_W - 1;

    logic [ACC_W-1:0] acc_nxt;
    logic             msb_rise;

    // Next accumulator value and detection of a 0->1 MSB transition.
    always_comb begin
        acc_nxt  = acc + step;
        msb_rise = !acc[MSB] && acc_nxt[MSB];
    end

    // Accumulator and half-rate divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc     <= '0;
            half_sq <= 1'b0;
        end else if (!freeze) begin
            acc <= acc_nxt;
            if (msb_rise) half_sq <= !half_sq;
        end
    end

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0) && !half_sq);

    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear) |=> $stable(acc) && $stable(half_sq));

    assert_half_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc[MSB]) |-> (half_sq != $past(half_sq)));

endmodule

// File: rtl/dds_sine_rom.sv
// Quarter-wave sine lookup expanded to a full unsigned cycle.
// Assumes: ph carries two quadrant bits above LUT_AW index bits.
module dds_sine_rom #(
    parameter int LUT_AW = 8,
    parameter int OUT_W  = 10
) (
    input  logic [LUT_AW+1:0] ph,
    output logic [OUT_W-1:0]  smp
);
    localparam int DEPTH = 1 << LUT_AW;
    localparam int AMP   = (1 << (OUT_W - 1)) - 1;
    localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W - 1));

    logic [OUT_W-2:0]  lut [DEPTH];
    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [OUT_W-1:0]  mag;

    // Constant table entries built at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        assign lut[g] = (OUT_W-1)'(dds_pkg::sine_mag(g, LUT_AW, AMP));
    end

    // Mirror the index in odd quadrants, negate in the lower half.
    always_comb begin
        quad = ph[LUT_AW+1:LUT_AW];
        idx  = quad[0] ? ~ph[LUT_AW-1:0] : ph[LUT_AW-1:0];
        mag  = {1'b0, lut[idx]};
        smp  = quad[1] ? (MID - 1'b1 - mag) : (MID + mag);
    end

endmodule

// File: rtl/dds_wave_shaper.sv
// Turns a phase word into sine, triangle or square output.
// Assumes: PH_W >= OUT_W + 1 and PH_W >= LUT_AW + 2.
module dds_wave_shaper
    import dds_pkg::*;
#(
    parameter int PH_W   = 12,
    parameter int OUT_W  = 10,
    parameter int LUT_AW = 8
) (
    input  logic [PH_W-1:0]  ph,
    input  logic             acc_msb,
    input  logic             half_sq,
    input  wave_ctl_t        ctl,
    output logic [OUT_W-1:0] sample,
    output logic             sq_out
);
    logic [OUT_W-1:0] sine_s;
    logic [OUT_W:0]   fold;
    logic [OUT_W-1:0] tri_s;
    logic             unused_ph;

    assign unused_ph = ^ph;

    dds_sine_rom #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_rom (
        .ph  (ph[PH_W-1 -: LUT_AW+2]),
        .smp (sine_s)
    );

    // Triangle by folding the top OUT_W+1 phase bits about the midpoint.
    always_comb begin
        fold  = ph[PH_W-1 -: OUT_W+1];
        tri_s = fold[OUT_W] ? ~fold[OUT_W-1:0] : fold[OUT_W-1:0];
    end

    // Mode selection and muting of the sample path.
    always_comb begin
        sq_out = ctl.sq_mode && (ctl.sq_full ? acc_msb : half_sq);
        if (ctl.mute)          sample = '0;
        else if (ctl.sq_mode)  sample = {OUT_W{sq_out}};
        else if (ctl.tri_mode) sample = tri_s;
        else                   sample = sine_s;
    end

endmodule

// File: rtl/wavegen_core.sv
// Top of the oscillator: bank selection, phase offset, shaping.
// Assumes: register values are stable, synchronous to clk.
module wavegen_core
    import dds_pkg::*;
#(
    parameter int ACC_W  = 28,
    parameter int PH_W   = 12,
    parameter int OUT_W  = 10,
    parameter int LUT_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_a,
    input  logic [ACC_W-1:0] freq_b,
    input  logic [PH_W-1:0]  phase_a,
    input  logic [PH_W-1:0]  phase_b,
    input  logic             freq_pick,
    input  logic             phase_pick,
    input  logic             acc_clear,
    input  logic             acc_freeze,
    input  logic             dac_mute,
    input  logic             sq_mode,
    input  logic             sq_full,
    input  logic             tri_mode,
    output logic [OUT_W-1:0] sample,
    output logic             sq_out
);
    wave_ctl_t        ctl;
    logic [ACC_W-1:0] step;
    logic [PH_W-1:0]  offs;
    logic [ACC_W-1:0] acc_w;
    logic             half_w;
    logic [PH_W-1:0]  ph;

    // Bundle control fields for the shaper.
    always_comb begin
        ctl.clear    = acc_clear;
        ctl.freeze   = acc_freeze;
        ctl.mute     = dac_mute;
        ctl.sq_mode  = sq_mode;
        ctl.sq_full  = sq_full;
        ctl.tri_mode = tri_mode;
    end

    // Bank selection and phase offset addition.
    always_comb begin
        step = freq_pick  ? freq_b  : freq_a;
        offs = phase_pick ? phase_b : phase_a;
        ph   = acc_w[ACC_W-1 -: PH_W] + offs;
    end

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctl.clear),
        .freeze  (ctl.freeze),
        .step    (step),
        .acc     (acc_w),
        .half_sq (half_w)
    );

    dds_wave_shaper #(.PH_W(PH_W), .OUT_W(OUT_W), .LUT_AW(LUT_AW)) u_shape (
        .ph      (ph),
        .acc_msb (acc_w[ACC_W-1]),
        .half_sq (half_w),
        .ctl     (ctl),
        .sample  (sample),
        .sq_out  (sq_out)
    );

    // R1 and R2: advance equals the word chosen by the bank select.
    assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clear && !acc_freeze) |=>
        (acc_w == $past(acc_w) + (($past(freq_pick)) ? $past(freq_b) : $past(freq_a))));

    assert_mute_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dac_mute |-> (sample == '0));

    assert_sq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_mode |-> !sq_out);

endmodule

// File: tb/test_wavegen_core.sv
`timescale 1ns/1ps
module test_wavegen_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] freq_a = '0, freq_b = '0;
    logic [11:0] phase_a = '0, phase_b = '0;
    logic        freq_pick = 0, phase_pick = 0, acc_clear = 0, acc_freeze = 0;
    logic        dac_mute = 0, sq_mode = 0, sq_full = 0, tri_mode = 0;
    logic [9:0]  sample;
    logic        sq_out;

    int          checks = 0;
    int          errors = 0;
    logic [27:0] m_acc = '0;
    logic        m_div = 1'b0;

    always #4 clk = ~clk;

    wavegen_core i_wavegen_core (
        .clk(clk), .rst_n(rst_n), .freq_a(freq_a), .freq_b(freq_b),
        .phase_a(phase_a), .phase_b(phase_b), .freq_pick(freq_pick),
        .phase_pick(phase_pick), .acc_clear(acc_clear), .acc_freeze(acc_freeze),
        .dac_mute(dac_mute), .sq_mode(sq_mode), .sq_full(sq_full),
        .tri_mode(tri_mode), .sample(sample), .sq_out(sq_out)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Accumulator model applied at each rising edge (R1, R4, R5, R9).
    task automatic model_edge();
        logic [27:0] nxt;
        if (!rst_n || acc_clear) begin
            m_acc = '0;
            m_div = 1'b0;
        end else if (!acc_freeze) begin
            nxt = m_acc + (freq_pick ? freq_b : freq_a);
            if (!m_acc[27] && nxt[27]) m_div = ~m_div;
            m_acc = nxt;
        end
    endtask

    // Compare both outputs with values derived from the requirements.
    task automatic check_out(input string tag);
        logic [11:0] ph;
        logic [10:0] q;
        logic        e_sq;
        int          e_s;
        real         ideal, diff;
        bit          ok;
        ph   = m_acc[27:16] + (phase_pick ? phase_b : phase_a);
        e_sq = sq_mode && (sq_full ? m_acc[27] : m_div);
        checks++;
        if (sq_out !== e_sq) begin
            errors++;
            $display("FAIL R8 sq_out: actual %0b expected %0b", sq_out, e_sq);
        end
        checks++;
        ok = 1'b1;
        e_s = 0;
        if (dac_mute)      e_s = 0;
        else if (sq_mode)  e_s = e_sq ? 1023 : 0;
        else if (tri_mode) begin
            q   = ph[11:1];
            e_s = q[10] ? 1023 - int'(q[9:0]) : int'(q[9:0]);
        end
        if (!dac_mute && !sq_mode && !tri_mode) begin
            ideal = 511.5 + 511.5 * $sin(2.0 * 3.14159265358979 * (real'(ph[11:2]) + 0.5) / 1024.0);
            diff  = real'(sample) - ideal;
            if (diff < 0.0) diff = -diff;
            ok = (diff <= 2.0);
            e_s = int'(ideal);
        end else begin
            ok = (int'(sample) == e_s);
        end
        if (!ok) begin
            errors++;
            $display("FAIL %s sample: actual %0d expected %0d (phase %0d)", tag, sample, e_s, ph);
        end
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            check_out(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Reset state: accumulator zero, sine at phase 0 (R1, R6).
        run(4, "R1");
        rst_n = 1'b1;
        // Full sine sweep, one phase code per cycle (R1, R6).
        freq_a = 28'd1 << 16;
        run(4096, "R6");
        // Bank B frequency with a fractional part and bank B offset (R2, R3).
        freq_b = (28'd3 << 16) + 28'd12345;
        phase_b = 12'd1000;
        freq_pick = 1; phase_pick = 1;
        run(1500, "R2");
        // Triangle sweep with a bank A offset (R3, R7).
        freq_pick = 0; phase_pick = 0; phase_a = 12'd77; tri_mode = 1;
        run(4096, "R7");
        // Clear holds zero; release resumes (R4).
        phase_a = 12'd0;
        acc_clear = 1; acc_freeze = 1;
        run(3, "R4");
        acc_clear = 0; acc_freeze = 0;
        run(20, "R4");
        // Freeze keeps the phase (R5).
        acc_freeze = 1;
        run(6, "R5");
        acc_freeze = 0;
        run(10, "R5");
        // Full-rate square, triangle select ignored (R8).
        freq_a = 28'd1 << 22; sq_mode = 1; sq_full = 1;
        run(300, "R8");
        // Half-rate square from MSB rises (R9).
        sq_full = 0;
        run(400, "R9");
        // Mute in square mode: sq_out continues, sample zero (R10).
        dac_mute = 1;
        run(200, "R10");
        // Mute in sine mode (R10).
        sq_mode = 0; tri_mode = 0;
        run(100, "R10");
        dac_mute = 0;
        run(50, "R6");
        summary();
        $finish;
    end
endmodule